// File: doc/BRIEF.md
# Double-Buffered BCD Clock Calendar

This block keeps calendar time in packed BCD: century, year, month, date, day of week, hours, minutes and seconds on a 24-hour clock. A one-clock-wide strobe marks each elapsed second. On that strobe, all carries from seconds up to century resolve in the same clock cycle. The carries take account of month lengths and leap years, including the century-year rule.

Two register banks hold the time. The counting bank advances on every second strobe while the oscillator is enabled. The visible bank is what the host sees through a 4-bit register address, separate read and write strobes, and an 8-bit data bus. Two control bits stop the visible bank from following the counting bank. With reads held, the host can read a frozen, consistent time while counting carries on. With writes held, the host can load a new time field by field. Releasing the write hold commits the loaded time to the counting bank in a single cycle. A stop bit in the seconds register halts counting altogether, and it comes out of reset set.

Top module: `rtc_dual_bank`

## Requirements
- R1: After reset, registers 8h, Ah, Bh and Fh read 00h; registers Ch, Dh and Eh read 01h; register 9h reads 80h (oscillator stopped); registers 0h–7h read 00h.
- R2: While bit 7 of register 9h is 1, second strobes do not change the time. A write to 9h always updates bit 7, and writing it 0 starts counting.
- R3: On a second strobe, seconds 59 wrap to 00 and carry into minutes, minutes 59 into hours, and hours 23 into the date and the day of week. All of these resolve in the cycle of that strobe, and the day of week wraps from 07 to 01.
- R4: Dates wrap after 30 in months 04, 06, 09 and 11 and after 31 in the other months except 02. Month 12 wraps to 01 and carries into the year.
- R5: February ends on 29 in a leap year and on 28 otherwise. A year that is not 00 is a leap year when it is divisible by 4. Year 00 is a leap year when the century is divisible by 4.
- R6: Year 99 wraps to 00 and increments the century, and century 39 wraps to 00.
- R7: Setting bit 6 of register 8h freezes the visible time while counting continues. Clearing it makes the visible registers show the current count on the next read.
- R8: Setting bit 7 of register 8h freezes the visible time and enables field writes to 8h–Fh. A write to 8h that clears bit 7 commits the visible values to the counting bank, including the century carried by that same write, and counting resumes from them.
- R9: Writes to the time fields of 8h–Fh are ignored while bit 7 of register 8h is 0.
- R10: Registers 0h–7h always read 00h, and writes to them change nothing.
- R11: rdData takes the addressed register value on the clock edge where rdEn is high, and it holds its value on edges where rdEn is low.
- R12: Field layout: 8h = {write-hold, read-hold, century[5:0]}; 9h = {stop, seconds[6:0]}; Ah minutes[6:0]; Bh hours[5:0]; Ch day[2:0]; Dh date[5:0]; Eh month[4:0]; Fh year[7:0]. Unused upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle strobe marking one elapsed second |
| regAddr | input | 4 | Register select |
| wrEn | input | 1 | Write strobe for the addressed register |
| rdEn | input | 1 | Read strobe; captures the addressed register into rdData |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |

## Verification
The bench sweeps February end-of-month across every year 00–99 under two centuries. A design that tests only the two-digit year for leap years would pass year 00 wrongly in one of the two centuries. It also drives each month's last day in a common year, a leap year and year 00. A wrong month-length table shows up as a date of 31 in a 30-day month, or as a missed carry into the month. A long run of consecutive strobes across hour and day boundaries is compared tick by tick against an arithmetic model, which catches a carry that lands one cycle late or a day of week that never wraps. The hold tests target a visible bank that keeps following the count, a commit that drops the century carried by the releasing write, and field writes that leak into a running clock.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 8;
  localparam int IDX_W      = ADDR_W - 1;
  localparam int NUM_FIELDS = 2 ** IDX_W;

  // field index = low address bits of registers 8h..Fh
  localparam int IDX_CENT  = 0;
  localparam int IDX_SEC   = 1;
  localparam int IDX_MIN   = 2;
  localparam int IDX_HOUR  = 3;
  localparam int IDX_DAY   = 4;
  localparam int IDX_DATE  = 5;
  localparam int IDX_MONTH = 6;
  localparam int IDX_YEAR  = 7;

  typedef logic [NUM_FIELDS-1:0][DATA_W-1:0] rtc_bank_t;

  typedef struct packed {
    logic [NUM_FIELDS-1:0] load;
    logic                  commit;
    logic                  track;
    logic                  advance;
    logic                  rHalt;
    logic                  wHalt;
    logic                  oscStop;
  } rtc_ctl_t;

  function automatic logic [DATA_W-1:0] fieldMask(input int idx);
    case (idx)
      IDX_CENT:  return 8'h3F;
      IDX_SEC:   return 8'h7F;
      IDX_MIN:   return 8'h7F;
      IDX_HOUR:  return 8'h3F;
      IDX_DAY:   return 8'h07;
      IDX_DATE:  return 8'h3F;
      IDX_MONTH: return 8'h1F;
      default:   return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    return (v[3:0] == 4'h9) ? {v[7:4] + 4'h1, 4'h0} : v + 8'h01;
  endfunction

  // two-digit BCD divisible by 4: even tens with units 0/4/8, odd tens with units 2/6
  function automatic logic div4Bcd(input logic [7:0] v);
    if (v[4]) return (v[3:0] == 4'h2) || (v[3:0] == 4'h6);
    return (v[3:0] == 4'h0) || (v[3:0] == 4'h4) || (v[3:0] == 4'h8);
  endfunction

  function automatic logic [7:0] lastDate(input logic [7:0] month, input logic leap);
    case (month)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic rtc_bank_t resetBank();
    rtc_bank_t b;
    b = '0;
    b[IDX_DAY]   = 8'h01;
    b[IDX_DATE]  = 8'h01;
    b[IDX_MONTH] = 8'h01;
    return b;
  endfunction
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output rtc_ctl_t          ctl
);
  logic rHalt, wHalt, oscStop;
  logic rHaltNext, wHaltNext, oscNext;
  logic hitCtl, hitSec;
  logic [NUM_FIELDS-1:0] loadVec;

  assign hitCtl = wrEn && (regAddr == ADDR_W'(NUM_FIELDS + IDX_CENT));
  assign hitSec = wrEn && (regAddr == ADDR_W'(NUM_FIELDS + IDX_SEC));

  assign rHaltNext = hitCtl ? wrData[6] : rHalt;
  assign wHaltNext = hitCtl ? wrData[7] : wHalt;
  assign oscNext   = hitSec ? wrData[7] : oscStop;

  // field loads only when the write hold was already in force
  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_load
    assign loadVec[i] = wrEn && wHalt && regAddr[ADDR_W-1] &&
                        (regAddr[IDX_W-1:0] == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rHalt   <= 1'b0;
      wHalt   <= 1'b0;
      oscStop <= 1'b1;
    end else begin
      rHalt   <= rHaltNext;
      wHalt   <= wHaltNext;
      oscStop <= oscNext;
    end
  end

  always_comb begin
    ctl.load    = loadVec;
    ctl.commit  = hitCtl && wHalt && !wrData[7];
    ctl.track   = !rHaltNext && !wHaltNext;
    ctl.advance = secTick && !oscStop;
    ctl.rHalt   = rHalt;
    ctl.wHalt   = wHalt;
    ctl.oscStop = oscStop;
  end
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter logic [7:0] CENT_LAST = 8'h39
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtc_ctl_t          ctl,
  input  logic [DATA_W-1:0] wrData,
  output rtc_bank_t         extBank
);
  rtc_bank_t intBank, countNext, extWr, intNext, extNext;
  logic leapNow;

  assign leapNow = (intBank[IDX_YEAR] != 8'h00) ? div4Bcd(intBank[IDX_YEAR])
                                                : div4Bcd(intBank[IDX_CENT]);

  // full carry chain resolved in the strobe cycle
  always_comb begin
    countNext = intBank;
    if (ctl.advance) begin
      if (intBank[IDX_SEC] != 8'h59) countNext[IDX_SEC] = bcdInc(intBank[IDX_SEC]);
      else begin
        countNext[IDX_SEC] = 8'h00;
        if (intBank[IDX_MIN] != 8'h59) countNext[IDX_MIN] = bcdInc(intBank[IDX_MIN]);
        else begin
          countNext[IDX_MIN] = 8'h00;
          if (intBank[IDX_HOUR] != 8'h23) countNext[IDX_HOUR] = bcdInc(intBank[IDX_HOUR]);
          else begin
            countNext[IDX_HOUR] = 8'h00;
            countNext[IDX_DAY]  = (intBank[IDX_DAY] == 8'h07) ? 8'h01 : bcdInc(intBank[IDX_DAY]);
            if (intBank[IDX_DATE] != lastDate(intBank[IDX_MONTH], leapNow))
              countNext[IDX_DATE] = bcdInc(intBank[IDX_DATE]);
            else begin
              countNext[IDX_DATE] = 8'h01;
              if (intBank[IDX_MONTH] != 8'h12) countNext[IDX_MONTH] = bcdInc(intBank[IDX_MONTH]);
              else begin
                countNext[IDX_MONTH] = 8'h01;
                if (intBank[IDX_YEAR] != 8'h99) countNext[IDX_YEAR] = bcdInc(intBank[IDX_YEAR]);
                else begin
                  countNext[IDX_YEAR] = 8'h00;
                  countNext[IDX_CENT] = (intBank[IDX_CENT] == CENT_LAST) ? 8'h00
                                                                          : bcdInc(intBank[IDX_CENT]);
                end
              end
            end
          end
        end
      end
    end
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_wr
    assign extWr[i] = ctl.load[i] ? (wrData & fieldMask(i)) : extBank[i];
  end

  assign intNext = ctl.commit ? extWr : countNext;
  assign extNext = ctl.track ? intNext : extWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intBank <= resetBank();
      extBank <= resetBank();
    end else begin
      intBank <= intNext;
      extBank <= extNext;
    end
  end
endmodule

// File: rtl/rtc_dual_bank.sv
module rtc_dual_bank
  import rtc_pkg::*;
#(
  parameter logic [7:0] CENT_LAST = 8'h39
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  rtc_ctl_t          ctl;
  rtc_bank_t         extBank;
  logic [DATA_W-1:0] readVal;
  logic [IDX_W-1:0]  fieldIdx;

  rtc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .secTick(secTick), .regAddr(regAddr),
    .wrEn(wrEn), .wrData(wrData), .ctl(ctl)
  );

  rtc_datapath #(.CENT_LAST(CENT_LAST)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData), .extBank(extBank)
  );

  assign fieldIdx = regAddr[IDX_W-1:0];

  always_comb begin
    readVal = '0;
    if (regAddr[ADDR_W-1]) begin
      readVal = extBank[fieldIdx];
      if (fieldIdx == IDX_W'(IDX_CENT))
        readVal = {ctl.wHalt, ctl.rHalt, extBank[IDX_CENT][5:0]};
      else if (fieldIdx == IDX_W'(IDX_SEC))
        readVal = {ctl.oscStop, extBank[IDX_SEC][6:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= readVal;
  end
endmodule

// File: rtl/rtc_dual_bank_chk.sv
module rtc_dual_bank_chk
  import rtc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] rdData,
  input rtc_ctl_t          ctl,
  input rtc_bank_t         extBank
);
  a_r11_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  a_r10_low_addr_zero: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rdEn) && !$past(regAddr[ADDR_W-1])) |-> (rdData == '0));

  a_r7_read_hold_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rHalt && !wrEn) |=> $stable(extBank));

  a_r8_write_hold_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wHalt && !wrEn) |=> $stable(extBank));

  a_r2_stopped_no_count: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.oscStop && ctl.track && $past(ctl.track) && !wrEn) |=> $stable(extBank));
endmodule

bind rtc_dual_bank rtc_dual_bank_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regAddr(regAddr),
  .rdData(rdData), .ctl(ctl), .extBank(extBank)
);

// File: tb/tb_rtc_dual_bank.sv
module tb_rtc_dual_bank;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       secTick = 1'b0;
  logic [3:0] regAddr = '0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  // field order: 0 century,1 sec,2 min,3 hour,4 day,5 date,6 month,7 year (register 8h+index)
  int mdl[8];

  always #2.5 clk = ~clk;

  rtc_dual_bank dut (
    .clk(clk), .rstN(rstN), .secTick(secTick), .regAddr(regAddr),
    .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData), .rdData(rdData)
  );

  function automatic logic [7:0] toBcd(int v);
    return 8'(((v / 10) << 4) + (v % 10));
  endfunction

  function automatic int dim(int m, int y, int c);
    bit leap;
    leap = (y % 4 == 0) && (y != 0 || c % 4 == 0);
    if (m == 2) return leap ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic modelTick();
    mdl[1]++;
    if (mdl[1] == 60) begin
      mdl[1] = 0; mdl[2]++;
      if (mdl[2] == 60) begin
        mdl[2] = 0; mdl[3]++;
        if (mdl[3] == 24) begin
          mdl[3] = 0;
          mdl[4] = (mdl[4] == 7) ? 1 : mdl[4] + 1;
          mdl[5]++;
          if (mdl[5] > dim(mdl[6], mdl[7], mdl[0])) begin
            mdl[5] = 1; mdl[6]++;
            if (mdl[6] == 13) begin
              mdl[6] = 1; mdl[7]++;
              if (mdl[7] == 100) begin
                mdl[7] = 0;
                mdl[0] = (mdl[0] == 39) ? 0 : mdl[0] + 1;
              end
            end
          end
        end
      end
    end
  endtask

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    regAddr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic tick(bit model);
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
    if (model) modelTick();
  endtask

  task automatic setTime(int v[8]);
    wr(4'h8, 8'h80);
    for (int i = 1; i < 8; i++) wr(4'(8 + i), toBcd(v[i]));
    wr(4'h8, toBcd(v[0]));
    for (int i = 0; i < 8; i++) mdl[i] = v[i];
  endtask

  task automatic readAll(int v[8], bit wh, bit rh, string tag);
    logic [7:0] got;
    rd(4'h8, got);
    check({tag, " reg8h"}, got, {wh, rh, toBcd(v[0])[5:0]});
    for (int i = 1; i < 8; i++) begin
      rd(4'(8 + i), got);
      check($sformatf("%s reg%0hh", tag, 8 + i), got, toBcd(v[i]));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int t[8];
    int frozen[8];
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 / R10 / R12: reset values of every address
    for (int a = 0; a < 16; a++) begin
      logic [7:0] e;
      rd(4'(a), v);
      e = 8'h00;
      if (a == 9) e = 8'h80;
      if (a == 12 || a == 13 || a == 14) e = 8'h01;
      check($sformatf("R1 reset reg%0hh", a), v, e);
    end

    // R2: stopped oscillator ignores strobes
    repeat (3) tick(1'b0);
    rd(4'h9, v); check("R2 stopped seconds", v, 8'h80);
    // R9: seconds field ignored without write hold; bit 7 still clears the stop
    wr(4'h9, 8'h05);
    rd(4'h9, v); check("R9 sec write ignored, R2 stop cleared", v, 8'h00);
    tick(1'b0);
    rd(4'h9, v); check("R2 counting after start", v, 8'h01);
    wr(4'hA, 8'h30);
    rd(4'hA, v); check("R9 minutes write ignored", v, 8'h00);
    wr(4'hF, 8'h55);
    rd(4'hF, v); check("R9 year write ignored", v, 8'h00);

    // R10: writes to low addresses change nothing
    wr(4'h3, 8'hFF);
    rd(4'h3, v); check("R10 low address read", v, 8'h00);
    rd(4'h9, v); check("R10 seconds untouched", v, 8'h01);

    // R2: stop again via 9h, strobes frozen
    wr(4'h9, 8'h80);
    tick(1'b0);
    rd(4'h9, v); check("R2 restopped", v, 8'h81);

    // R5: February end across every year, two centuries
    for (int c = 19; c <= 20; c++) begin
      for (int y = 0; y < 100; y++) begin
        t = '{c, 59, 59, 23, (y % 7) + 1, 28, 2, y};
        setTime(t);
        tick(1'b1);
        readAll(mdl, 1'b0, 1'b0, $sformatf("R5 feb28 c%0d y%0d", c, y));
      end
    end
    // R5: leap-day itself rolls to March 1
    t = '{20, 59, 59, 23, 7, 29, 2, 24};
    setTime(t); tick(1'b1);
    readAll(mdl, 1'b0, 1'b0, "R5 feb29 R3 day wrap");

    // R4: every month end in a common, a leap and a 00 year
    for (int yi = 0; yi < 3; yi++) begin
      int yr;
      yr = (yi == 0) ? 23 : (yi == 1) ? 24 : 0;
      for (int m = 1; m <= 12; m++) begin
        t = '{21, 59, 59, 23, (m % 7) + 1, dim(m, yr, 21), m, yr};
        setTime(t); tick(1'b1);
        readAll(mdl, 1'b0, 1'b0, $sformatf("R4 month%0d y%0d", m, yr));
      end
    end

    // R6: year and century wrap
    t = '{19, 59, 59, 23, 3, 31, 12, 99};
    setTime(t); tick(1'b1);
    readAll(mdl, 1'b0, 1'b0, "R6 year99 to century20");
    t = '{39, 59, 59, 23, 3, 31, 12, 99};
    setTime(t); tick(1'b1);
    readAll(mdl, 1'b0, 1'b0, "R6 century39 wrap");

    // R3: long consecutive run against the model
    t = '{20, 50, 58, 23, 7, 30, 4, 25};
    setTime(t);
    for (int k = 0; k < 700; k++) begin
      tick(1'b1);
      readAll(mdl, 1'b0, 1'b0, "R3 run");
    end

    // R7: read hold freezes visible time while counting continues
    for (int i = 0; i < 8; i++) frozen[i] = mdl[i];
    wr(4'h8, 8'h40);
    repeat (5) tick(1'b1);
    readAll(frozen, 1'b0, 1'b1, "R7 frozen R12 ctl bit6");
    wr(4'h8, 8'h00);
    readAll(mdl, 1'b0, 1'b0, "R7 released");

    // R8: write hold, field loads, commit with century from the releasing write
    for (int i = 0; i < 8; i++) frozen[i] = mdl[i];
    wr(4'h8, 8'h80);
    repeat (3) tick(1'b0);
    readAll(frozen, 1'b1, 1'b0, "R8 held R12 ctl bit7");
    t = '{33, 17, 42, 11, 2, 14, 6, 77};
    for (int i = 1; i < 8; i++) wr(4'(8 + i), toBcd(t[i]));
    frozen[0] = mdl[0];
    for (int i = 1; i < 8; i++) frozen[i] = t[i];
    readAll(frozen, 1'b1, 1'b0, "R8 loaded visible");
    wr(4'h8, toBcd(33));
    for (int i = 0; i < 8; i++) mdl[i] = t[i];
    readAll(mdl, 1'b0, 1'b0, "R8 committed");
    tick(1'b1);
    readAll(mdl, 1'b0, 1'b0, "R8 resumed");

    // R11: rdData holds without rdEn
    rd(4'hB, v);
    check("R11 read hour", v, toBcd(mdl[3]));
    @(negedge clk); regAddr = 4'hF;
    repeat (2) @(negedge clk);
    check("R11 hold without rdEn", rdData, toBcd(mdl[3]));

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule